// File: doc/BRIEF.md
# Wait-State Bus Cycle Sequencer

This block sits between a processor core and its memory bus and runs one machine cycle at a time: an opcode fetch, an operand read or an operand write. The core hands over a cycle kind, an address, write data and a choice of base cycle length. The sequencer then walks through T states, one per clock, drives the address and strobes on the bus, and returns the read data with a one-clock done pulse. The base length is four T states (T1, T2, T3, T4), or three (T1, T2, T3) when the request selects the short form.

Slow memory stretches a cycle by holding the wait input. The wait input is looked at on the clock edge that ends T2 and on the edge that ends every inserted wait state (TW). Each high sample adds one more TW, during which address and strobes stay frozen. Read data is taken on the edge that ends the last strobe-active T state. The final T state has the strobes released, carries the done pulse, and can accept the next request so cycles run back to back.

States: ST_IDLE, ST_T1, ST_T2, ST_TW, ST_T3, ST_T4. Transitions: IDLE to T1 on accept; T1 to T2 always; T2 or TW to TW when wait is sampled high, else to T3; T3 to T4 in a four-state cycle; the final state (T3 short, T4 long) to T1 on accept, else to IDLE.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset, bus_addr, bus_wdata, bus_rd, bus_wr, bus_fetch and rsp_done are all zero and req_ready is one.
- R2: A request is taken on a rising edge where req_valid and req_ready are both high; req_ready is high only when idle or in the final T state, and low in every strobe-active T state.
- R3: Each T state lasts one clock and T1 follows the accepting edge; with no wait, a cycle with req_three_t=0 lasts 4 clocks (strobes high for 3) and with req_three_t=1 lasts 3 clocks (strobes high for 2).
- R4: The request address is on bus_addr from T1 through the final T state and does not change while a strobe is high; the strobes are high from T1 up to but not including the final T state.
- R5: bus_wait is sampled on the edge ending T2 and on the edge ending each TW; every high sample inserts one TW, so a cycle with n waits lasts base+n clocks (one wait turns 4 into 5).
- R6: bus_wait has no effect when sampled at the end of T1, of T3 in a four-state cycle, of the final T state or while idle.
- R7: rsp_rdata equals bus_rdata as sampled on the edge that ends the last strobe-active T state; it is valid while rsp_done is high.
- R8: A write (kind 2) raises bus_wr with bus_wdata equal to the request data over the whole strobe window, keeps bus_rd low, and returns rsp_rdata of zero; bus_rd and bus_wr are never high together.
- R9: Kind 0 is an opcode fetch: bus_fetch and bus_rd are both high in the strobe window; kinds 1 and 3 are operand reads with bus_rd high and bus_fetch low; bus_fetch is never high without bus_rd.
- R10: rsp_done is high for exactly one clock, in the final T state; if a request is held then, T1 of the next cycle comes on the next clock, otherwise the sequencer goes idle.
- R11: While idle, bus_addr, bus_wdata and bus_fetch are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T state per period |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request this clock |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| req_addr | input | ADDR_W | Cycle address |
| req_wdata | input | DATA_W | Write data |
| req_three_t | input | 1 | 1 selects the three-T-state base cycle |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | Address to memory |
| bus_wdata | output | DATA_W | Data to memory |
| bus_rdata | input | DATA_W | Data from memory |
| bus_rd | output | 1 | Read strobe (fetch and operand read) |
| bus_wr | output | 1 | Write strobe |
| bus_fetch | output | 1 | Marks an opcode fetch |
| bus_wait | input | 1 | Stretch request from memory |

## Verification
A state register stuck in or skipping TW shows as a strobe window one clock too long or short, seen at the done pulse of that very cycle, and a capture on the wrong edge returns data the memory model drove in a neighbouring T state, so rsp_rdata mismatches on the same done. A wrong latch of the cycle kind or address shows within the first strobe clock as a bad fetch flag, strobe or address. Noise on the wait input outside its sampling edges makes a design that samples at the wrong point lengthen cycles, which the length check catches at done; a ready or next-state slip at the final T state shows one clock later as a missing or early T1.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2,
        KIND_READX = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_TW   = 3'd3,
        ST_T3   = 3'd4,
        ST_T4   = 3'd5
    } tstate_e;

    function automatic logic kind_is_write(input kind_e k);
        return k == KIND_WRITE;
    endfunction

endpackage

// File: rtl/bcs_req_latch.sv
module bcs_req_latch
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [1:0]        in_kind,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic              in_three,
    output kind_e             kind_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              three_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= KIND_FETCH;
            addr_q  <= '0;
            wdata_q <= '0;
            three_q <= 1'b0;
        end else if (accept) begin
            kind_q  <= kind_e'(in_kind);
            addr_q  <= in_addr;
            wdata_q <= in_wdata;
            three_q <= in_three;
        end
    end

endmodule

// File: rtl/bcs_fsm.sv
module bcs_fsm
    import bcs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    three_q,
    input  logic    bus_wait,
    output tstate_e state,
    output logic    accept,
    output logic    ready,
    output logic    active,
    output logic    strobe,
    output logic    capture,
    output logic    done
);

    tstate_e state_nx;
    logic    final_st;

    // Final T state: T4 for the long form, T3 for the short one.
    always_comb begin
        final_st = 1'b0;
        unique case (state)
            ST_T3:   final_st = three_q;
            ST_T4:   final_st = 1'b1;
            default: final_st = 1'b0;
        endcase
    end

    assign ready  = (state == ST_IDLE) || final_st;
    assign accept = ready && req_valid;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = accept ? ST_T1 : ST_IDLE;
            ST_T1:   state_nx = ST_T2;
            ST_T2,
            ST_TW:   state_nx = bus_wait ? ST_TW : ST_T3;
            ST_T3:   begin
                if (three_q) state_nx = accept ? ST_T1 : ST_IDLE;
                else         state_nx = ST_T4;
            end
            ST_T4:   state_nx = accept ? ST_T1 : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Per-state outputs.
    always_comb begin
        active  = 1'b0;
        strobe  = 1'b0;
        capture = 1'b0;
        unique case (state)
            ST_IDLE: begin
                active = 1'b0;
            end
            ST_T1: begin
                active = 1'b1;
                strobe = 1'b1;
            end
            ST_T2, ST_TW: begin
                active  = 1'b1;
                strobe  = 1'b1;
                capture = three_q && !bus_wait;
            end
            ST_T3: begin
                active  = 1'b1;
                strobe  = !three_q;
                capture = !three_q;
            end
            ST_T4: begin
                active = 1'b1;
            end
            default: active = 1'b0;
        endcase
    end

    assign done = final_st;

    assert_wait_stretch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_T2 || state == ST_TW) && bus_wait) |=> (state == ST_TW));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_ready_final_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && state != ST_IDLE) |-> (done && !strobe));

    assert_t1_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (state == ST_T1));

endmodule

// File: rtl/bcs_bus_drive.sv
module bcs_bus_drive
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              strobe,
    input  logic              capture,
    input  kind_e             kind_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_fetch,
    output logic [DATA_W-1:0] rdata_q
);

    logic is_wr;

    always_comb begin
        is_wr     = kind_is_write(kind_q);
        bus_addr  = active ? addr_q : '0;
        bus_rd    = strobe && !is_wr;
        bus_wr    = strobe && is_wr;
        bus_fetch = strobe && (kind_q == KIND_FETCH);
        bus_wdata = (strobe && is_wr) ? wdata_q : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (capture) rdata_q <= is_wr ? '0 : bus_rdata;
    end

    assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |=> $stable(bus_addr));

    assert_rd_wr_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_rd, bus_wr}));

    assert_fetch_is_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_fetch |-> bus_rd);

    assert_wdata_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && $past(bus_wr)) |-> $stable(bus_wdata));

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_three_t,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_fetch,
    input  logic              bus_wait
);

    tstate_e           state;
    kind_e             kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              three_q;
    logic              accept;
    logic              active;
    logic              strobe;
    logic              capture;

    bcs_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .in_kind  (req_kind),
        .in_addr  (req_addr),
        .in_wdata (req_wdata),
        .in_three (req_three_t),
        .kind_q   (kind_q),
        .addr_q   (addr_q),
        .wdata_q  (wdata_q),
        .three_q  (three_q)
    );

    bcs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .three_q   (three_q),
        .bus_wait  (bus_wait),
        .state     (state),
        .accept    (accept),
        .ready     (req_ready),
        .active    (active),
        .strobe    (strobe),
        .capture   (capture),
        .done      (rsp_done)
    );

    bcs_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .strobe    (strobe),
        .capture   (capture),
        .kind_q    (kind_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .bus_rdata (bus_rdata),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_fetch (bus_fetch),
        .rdata_q   (rsp_rdata)
    );

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (bus_addr == '0 && !bus_rd && !bus_wr && !rsp_done));

endmodule

// File: tb/test_bus_cycle_seq.sv
module test_bus_cycle_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int MAXT = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_three_t = 1'b0;
    logic          rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_rd, bus_wr, bus_fetch;
    logic          bus_wait = 1'b0;

    bus_cycle_seq #(.ADDR_W(AW), .DATA_W(DW)) i_bus_cycle_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_three_t(req_three_t),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_fetch(bus_fetch), .bus_wait(bus_wait)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int issued   = 0;
    int finished = 0;

    logic [1:0]    e_kind [MAXT];
    logic [AW-1:0] e_addr [MAXT];
    logic [DW-1:0] e_wdata[MAXT];
    logic          e_three[MAXT];
    int            e_nw   [MAXT];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Memory model data: changes every strobe clock, so a capture on the wrong edge differs.
    function automatic logic [DW-1:0] mem_data(input logic [AW-1:0] a, input int k);
        return a[7:0] ^ a[15:8] ^ 8'(k * 29) ^ 8'h5a;
    endfunction

    function automatic int strobe_len(input logic three, input int nw);
        return (three ? 2 : 3) + nw;
    endfunction

    function automatic logic [DW-1:0] exp_rdata(input int idx);
        if (e_kind[idx] == 2'd2) return '0;
        return mem_data(e_addr[idx], strobe_len(e_three[idx], e_nw[idx]));
    endfunction

    // Memory-side model and monitor, acting on the falling edge.
    int k = 0;
    int cur = -1;
    int exp_next = 0;
    always @(negedge clk) begin
        logic strb;
        logic noise;
        if (rst_n) begin
            strb  = bus_rd || bus_wr;
            noise = 1'($urandom_range(0, 1));
            if (exp_next == 1)
                chk(strb && k == 0, "R10 next T1 right after done", 64'(strb), 1);
            if (exp_next == 2)
                chk(!strb && !rsp_done, "R10 idle after done", 64'(strb), 0);
            exp_next = 0;
            if (strb) begin
                if (k == 0) cur++;
                k++;
                chk(bus_addr == e_addr[cur], "R4 address during strobe", bus_addr, e_addr[cur]);
                chk(bus_rd == (e_kind[cur] != 2'd2), "R9 read strobe per kind", bus_rd, (e_kind[cur] != 2'd2));
                chk(bus_wr == (e_kind[cur] == 2'd2), "R8 write strobe per kind", bus_wr, (e_kind[cur] == 2'd2));
                chk(bus_fetch == (e_kind[cur] == 2'd0), "R9 fetch flag per kind", bus_fetch, (e_kind[cur] == 2'd0));
                if (e_kind[cur] == 2'd2)
                    chk(bus_wdata == e_wdata[cur], "R8 write data on bus", bus_wdata, e_wdata[cur]);
                chk(!req_ready, "R2 not ready in strobe state", req_ready, 0);
                chk(!rsp_done, "R10 no done in strobe state", rsp_done, 0);
                // Sampling points are k = 2 .. ; high for the first e_nw samples (R5), noise elsewhere (R6).
                if (k >= 2 && k <= e_nw[cur] + 1) bus_wait = 1'b1;
                else if (k >= 2 && k == e_nw[cur] + 2 && (k < strobe_len(e_three[cur], e_nw[cur]) || e_three[cur]))
                    bus_wait = 1'b0;
                else bus_wait = noise;
                bus_rdata = mem_data(bus_addr, k);
            end else if (rsp_done) begin
                chk(cur >= 0, "R10 done belongs to a cycle", cur, 0);
                if (cur >= 0) begin
                    chk(k == strobe_len(e_three[cur], e_nw[cur]), "R3/R5 strobe clocks", k,
                        strobe_len(e_three[cur], e_nw[cur]));
                    chk(rsp_rdata == exp_rdata(cur), "R7/R8 returned data", rsp_rdata, exp_rdata(cur));
                    chk(bus_addr == e_addr[cur], "R4 address in final T state", bus_addr, e_addr[cur]);
                end
                chk(req_ready, "R2 ready in final T state", req_ready, 1);
                exp_next = req_valid ? 1 : 2;
                k = 0;
                finished++;
                bus_wait  = noise;
                bus_rdata = 8'($urandom);
            end else begin
                chk(k == 0, "R10 done missing after strobes", k, 0);
                chk(bus_addr == '0 && bus_wdata == '0 && !bus_fetch, "R11 idle outputs quiet",
                    {bus_addr, bus_wdata}, 0);
                chk(req_ready, "R2 ready when idle", req_ready, 1);
                bus_wait  = noise;
                bus_rdata = 8'($urandom);
            end
        end
    end

    task automatic issue(input logic [1:0] kind, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic three, input int nw);
        e_kind[issued]  = kind;
        e_addr[issued]  = a;
        e_wdata[issued] = d;
        e_three[issued] = three;
        e_nw[issued]    = nw;
        issued++;
        req_valid   = 1'b1;
        req_kind    = kind;
        req_addr    = a;
        req_wdata   = d;
        req_three_t = three;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    // Watchdog.
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired: finished=%0d expected=%0d", finished, issued);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(bus_addr == '0 && bus_wdata == '0, "R1 reset bus lines", {bus_addr, bus_wdata}, 0);
        chk(!bus_rd && !bus_wr && !bus_fetch, "R1 reset strobes", {bus_rd, bus_wr, bus_fetch}, 0);
        chk(!rsp_done && req_ready, "R1 reset done/ready", {rsp_done, req_ready}, 1);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // Directed corner cases.
        issue(2'd1, 16'h0100, 8'h00, 1'b0, 0);   // R3 four-state read
        issue(2'd0, 16'h0101, 8'h00, 1'b0, 1);   // R5 one wait: 5 clocks
        issue(2'd2, 16'h2000, 8'hc3, 1'b1, 0);   // R8 short write
        issue(2'd3, 16'h3003, 8'h00, 1'b1, 1);   // R9 kind 3 read, R5
        issue(2'd2, 16'hfffe, 8'h7e, 1'b0, 5);   // R5 long stretch write
        issue(2'd0, 16'h0001, 8'h00, 1'b1, 4);   // R9 short fetch stretched
        repeat (3) @(posedge clk);
        #1;
        // Constrained random traffic with idle gaps and back-to-back runs.
        for (int i = 0; i < 300; i++) begin
            int gap;
            gap = $urandom_range(0, 3);
            if (gap == 3) begin
                repeat ($urandom_range(1, 3)) @(posedge clk);
                #1;
            end
            issue(2'($urandom_range(0, 3)), 16'($urandom), 8'($urandom),
                  1'($urandom_range(0, 1)), $urandom_range(0, 3));
        end
        while (finished < issued) @(posedge clk);
        repeat (3) @(posedge clk);
        chk(finished == issued, "R10 every cycle completed once", finished, issued);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule